// File: doc/BRIEF.md
# Peripheral Clock Divider with Parent Select and Gate

This block derives a slow peripheral clock from one of four parent clocks. Each parent is presented as a single-cycle tick strobe in the system clock domain. One 32-bit control word selects the parent and sets two divide stages. The first stage is a power-of-two prescaler that passes one parent tick in every 1, 2, 4 or 8. The second stage is an integer divider that passes one prescaled tick in every 1 to 16. An enable bit gates the result. The output is a one-cycle tick strobe. The block can only divide, so its rate never exceeds the rate of the selected parent.

A small controller has two states. ST_OFF means gated, with no counting. ST_RUN means counting and issuing ticks. A write with the enable bit set takes the transition OFF_TO_RUN. A write with the enable bit clear takes the transition RUN_TO_OFF. Any other write, and any cycle without a write, leaves the state unchanged. Every write also clears both divider counters, so the new ratio applies from the first tick after the write.

Top module: `modclk_gen`

## Requirements
- R1: After reset, `rd_data` reads 0 and `tick_out` is low. This means gated, parent 0 and a total divide of 1.
- R2: `rd_data` returns the control word with m in bits 3:0, p in bits 17:16, the parent select in bits 25:24 and the enable in bit 31. All other bits read as zero, whatever value was written to them.
- R3: While the enable bit (bit 31) is clear, `tick_out` stays low whatever the parent inputs do.
- R4: Only `parent_tick[sel]` is counted. Ticks on the three unselected parent inputs have no effect on `tick_out`.
- R5: While enabled, `tick_out` is high for exactly one cycle on every (2^p)*(m+1)-th selected parent tick. It goes high in the cycle after the clock edge that samples that parent tick.
- R6: With m=0 and p=0, every selected parent tick produces an output tick one cycle later. The output never exceeds the parent rate.
- R7: With m=15 and p=3, the output tick comes on every 128th selected parent tick.
- R8: Every register write clears both divider counters. A parent tick in the write cycle is not counted, `tick_out` is low in the cycle after the write, and the first output tick after the write uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| parent_tick | input | 4 | Tick strobes of the four parent clocks |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| rd_data | output | 32 | Control word readback |
| tick_out | output | 1 | Divided, gated output tick |

## Verification
The bench targets the ends of the divide range. At m=0, p=0 a design with an off-by-one counter would skip every other tick. At m=15, p=3 a counter that is too narrow would wrap early and tick at a fraction of 128. It writes new ratios in the middle of a count, with a parent tick in the same cycle as the write. A design that did not restart its counters would issue the first output after the write too early. It also drives busy ticks on the unselected parents and toggles the enable bit while parents are active. This shows up a wrong mux index or a leaky gate as stray output ticks. Writing all ones exposes readback bits that should be tied to zero.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

    localparam int M_W     = 4;
    localparam int P_W     = 2;
    localparam int SEL_W   = 2;
    localparam int WORD_W  = 32;

    localparam int M_LSB   = 0;
    localparam int P_LSB   = 16;
    localparam int SEL_LSB = 24;
    localparam int EN_BIT  = 31;

    localparam int PRE_W   = (1 << P_W) - 1;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_RUN = 1'b1
    } run_state_t;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        logic [P_W-1:0]   p;
        logic [M_W-1:0]   m;
    } cfg_t;

endpackage

// File: rtl/modclk_regs.sv
module modclk_regs
    import modclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output cfg_t              cfg,
    output logic [WORD_W-1:0] rd_data
);

    cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.en  <= wr_data[EN_BIT];
            cfg_q.sel <= wr_data[SEL_LSB +: SEL_W];
            cfg_q.p   <= wr_data[P_LSB +: P_W];
            cfg_q.m   <= wr_data[M_LSB +: M_W];
        end
    end

    always_comb begin
        rd_data                    = '0;
        rd_data[EN_BIT]            = cfg_q.en;
        rd_data[SEL_LSB +: SEL_W]  = cfg_q.sel;
        rd_data[P_LSB +: P_W]      = cfg_q.p;
        rd_data[M_LSB +: M_W]      = cfg_q.m;
    end

    assign cfg = cfg_q;

    // R2: unused bits never read back as ones
    p_zero_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~(32'h8000_0000 | 32'h0300_0000 | 32'h0003_0000 | 32'h0000_000F)) == '0);

endmodule

// File: rtl/modclk_ctrl.sv
module modclk_ctrl
    import modclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              run,
    output logic              restart
);

    run_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (wr_en && wr_data[EN_BIT])  state_d = ST_RUN; // OFF_TO_RUN
            ST_RUN: if (wr_en && !wr_data[EN_BIT]) state_d = ST_OFF; // RUN_TO_OFF
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        run     = (state_q == ST_RUN) && !wr_en;
        restart = wr_en;
    end

    // R3: a disabling write always lands in ST_OFF
    p_off_after_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[EN_BIT]) |=> (state_q == ST_OFF));

endmodule

// File: rtl/modclk_prescale.sv
module modclk_prescale
    import modclk_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           advance,
    input  logic [P_W-1:0] p,
    output logic           pre_tick
);

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim      = PRE_W'((1 << p) - 1);
        pre_tick = advance && (cnt_q == lim);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clear)    cnt_q <= '0;
        else if (pre_tick) cnt_q <= '0;
        else if (advance)  cnt_q <= cnt_q + 1'b1;
    end

    // R5: prescale count stays within its ratio
    p_pre_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim);
    // R8: clear leaves the prescaler at zero
    p_pre_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/modclk_intdiv.sv
module modclk_intdiv
    import modclk_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clear,
    input  logic           advance,
    input  logic [M_W-1:0] m,
    output logic           fire
);

    logic [M_W-1:0] cnt_q;

    assign fire = advance && (cnt_q == m);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (fire)    cnt_q <= '0;
        else if (advance) cnt_q <= cnt_q + 1'b1;
    end

    // R5: integer count stays within m
    p_int_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= m);
    // R8: clear leaves the integer divider at zero
    p_int_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

endmodule

// File: rtl/modclk_gen.sv
module modclk_gen
    import modclk_pkg::*;
#(
    parameter int NUM_PARENTS = 1 << SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PARENTS-1:0] parent_tick,
    input  logic                   wr_en,
    input  logic [WORD_W-1:0]      wr_data,
    output logic [WORD_W-1:0]      rd_data,
    output logic                   tick_out
);

    cfg_t cfg;
    logic run, restart, sel_tick, pre_tick, fire;

    modclk_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    modclk_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .run     (run),
        .restart (restart)
    );

    assign sel_tick = parent_tick[cfg.sel];

    modclk_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .advance  (run && sel_tick),
        .p        (cfg.p),
        .pre_tick (pre_tick)
    );

    modclk_intdiv u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (restart),
        .advance (pre_tick),
        .m       (cfg.m),
        .fire    (fire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick_out <= 1'b0;
        else        tick_out <= fire;
    end

    // R3: gated output is silent
    p_quiet_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.en |-> !tick_out);
    // R4: every output tick follows a selected parent tick
    p_from_parent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_out |-> $past(sel_tick));
    // R8: no output right after a write
    p_restart_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tick_out);

endmodule

// File: tb/modclk_gen_bench.sv
module modclk_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  parent_tick = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        tick_out;

    int checks = 0;
    int errors = 0;

    logic       m_en = 1'b0;
    logic [1:0] m_sel = '0;
    int         m_ratio = 1;
    int         m_cnt = 0;
    logic       m_exp = 1'b0;

    always #2 clk = ~clk;

    modclk_gen u_modclk_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .parent_tick (parent_tick),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .tick_out    (tick_out)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input bit en, input int sel, input int p, input int m);
        return {en, 5'd0, 2'(sel), 6'd0, 2'(p), 12'd0, 4'(m)};
    endfunction

    task automatic wr(input logic [31:0] d, input logic [3:0] pt, input string req);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; parent_tick = pt;
        @(posedge clk);
        m_en = d[31]; m_sel = d[25:24];
        m_ratio = (1 << d[17:16]) * (int'(d[3:0]) + 1);
        m_cnt = 0; m_exp = 1'b0;
        @(negedge clk);
        wr_en = 1'b0; parent_tick = '0;
        chk(tick_out == 1'b0, req, 32'(tick_out), 32'd0);
        chk(rd_data == (d & 32'h8303_000F), "R2", rd_data, d & 32'h8303_000F);
    endtask

    task automatic step(input logic [3:0] pt, input string req);
        parent_tick = pt;
        @(posedge clk);
        m_exp = 1'b0;
        if (m_en && pt[m_sel]) begin
            m_cnt++;
            if (m_cnt == m_ratio) begin m_exp = 1'b1; m_cnt = 0; end
        end
        @(negedge clk);
        chk(tick_out == m_exp, req, 32'(tick_out), 32'(m_exp));
    endtask

    task automatic t_reset();
        chk(rd_data == 32'd0, "R1", rd_data, 32'd0);
        chk(tick_out == 1'b0, "R1", 32'(tick_out), 32'd0);
    endtask

    task automatic t_readback();
        wr(32'hFFFF_FFFF, 4'h0, "R2");
        wr(32'h7CFC_FFF0, 4'h0, "R2");
        wr(32'h0000_0000, 4'h0, "R2");
    endtask

    task automatic t_disabled();
        wr(mk(0, 0, 0, 0), 4'hF, "R3");
        for (int i = 0; i < 20; i++) step(4'hF, "R3");
        wr(mk(1, 1, 0, 0), 4'h0, "R3");
        for (int i = 0; i < 6; i++) step(4'h2, "R3");
        wr(mk(0, 1, 0, 0), 4'h2, "R3");
        for (int i = 0; i < 10; i++) step(4'h2, "R3");
    endtask

    task automatic t_passthrough();
        wr(mk(1, 0, 0, 0), 4'h1, "R6");
        for (int i = 0; i < 12; i++) step(4'h1, "R6");
        for (int i = 0; i < 12; i++) step(4'((i % 3 == 0) ? 1 : 0), "R6");
    endtask

    task automatic t_select();
        wr(mk(1, 2, 1, 2), 4'h0, "R4");
        for (int i = 0; i < 40; i++) step(4'hB, "R4");
        for (int i = 0; i < 60; i++) step({1'b1, 1'($urandom), 2'b11}, "R4");
        wr(mk(1, 3, 0, 1), 4'h0, "R4");
        for (int i = 0; i < 30; i++) step({1'($urandom), 3'b111}, "R4");
    endtask

    task automatic t_ratio();
        wr(mk(1, 0, 0, 4), 4'h0, "R5");
        for (int i = 0; i < 30; i++) step(4'h1, "R5");
        wr(mk(1, 1, 2, 0), 4'h0, "R5");
        for (int i = 0; i < 30; i++) step(4'h2, "R5");
        wr(mk(1, 0, 1, 3), 4'h0, "R5");
        for (int i = 0; i < 80; i++) step(4'(($urandom % 3 == 0) ? 1 : 0), "R5");
    endtask

    task automatic t_max();
        wr(mk(1, 1, 3, 15), 4'h0, "R7");
        for (int i = 0; i < 300; i++) step(4'h2, "R7");
    endtask

    task automatic t_restart();
        wr(mk(1, 0, 1, 3), 4'h0, "R8");
        for (int i = 0; i < 5; i++) step(4'h1, "R8");
        wr(mk(1, 0, 0, 1), 4'h1, "R8");
        for (int i = 0; i < 9; i++) step(4'h1, "R8");
        step(4'h1, "R8");
        wr(mk(1, 0, 1, 1), 4'h1, "R8");
        for (int i = 0; i < 10; i++) step(4'h1, "R8");
    endtask

    initial begin
        #400000;
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_disabled();
        t_passthrough();
        t_select();
        t_ratio();
        t_max();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule